// File: doc/BRIEF.md
# Single-Lane PRBS-7 Self-Test Checker

This block sits on the receive side of a serial lane and judges a PRBS-7 self-test. It takes recovered bits, each marked by a valid strobe, together with a lock indicator from the clock-recovery logic and a test-mode flag. Once the flag has been held long enough, the checker loads its reference generator from the first seven bits it receives. From then on it predicts every following bit and counts each bit that does not match the prediction.

Two results are kept. The first is a 7-bit error count that stops at its maximum. The second is a pass flag. It rises once a configurable number of symbols has been received while the lane is locked, and after that it stays high whatever errors follow. In test mode the lane's 8-bit output byte shows these two results. Outside test mode the normal data byte goes through unchanged. Both cases pass through one output register.

Top module: `prbs7_lane_checker`

## Requirements
- R1: When test mode is not engaged, `data_out` equals the `data_in` value from the previous clock edge. While `rst` is high, `data_out` is 0.
- R2: Test mode engages only after `test_en` has been high for `ENTRY_CYC` consecutive clock edges, and it drops on the first edge at which `test_en` is low. `data_out` follows one edge later. `ENTRY_CYC` must be at most 128.
- R3: After test mode engages or lock returns, the first 7 valid bits load the reference generator and are never counted as errors. Comparison starts on the 8th valid bit.
- R4: Each valid bit from the 8th onward that differs from b[n-7] XOR b[n-6] of the reference sequence adds one to the error count.
- R5: The error count stops at 127 and never wraps.
- R6: The pass flag rises when the `PASS_COUNT`-th valid bit is received while locked, and not before.
- R7: Once high, the pass flag stays high for as long as test mode stays engaged, whatever errors or lock loss follow.
- R8: Bits are ignored while `lock` is low. If lock is lost before the pass flag has risen, the symbol count, the error count and the pass flag all clear. Lock loss after the pass flag has risen leaves all of them unchanged.
- R9: In test mode, bit 0 of `data_out` is the pass flag and bits 7:1 are the error count.
- R10: When test mode drops, the symbol count, the error count and the pass flag clear, so the next entry starts from {0,0}.
- R11: Bits presented with `bit_vld` low are neither counted nor compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst | input | 1 | Synchronous reset, active high |
| test_en | input | 1 | Test-mode request flag |
| lock | input | 1 | Receiver lock indicator |
| bit_vld | input | 1 | Strobe marking `bit_in` as a new symbol |
| bit_in | input | 1 | Recovered lane bit |
| data_in | input | 8 | Normal data byte |
| data_out | output | 8 | Registered data byte, or status {error count, pass} in test mode |

## Verification
The hardest state to reach is a checker that has already passed and then sees both lock loss and a burst of errors. At that point R7 and R8 pull in opposite directions, and a clear that does not check the pass flag would silently erase the result. The bench sets the symbol threshold to 40. It drives a clean run to the threshold, then a stream of wrong bits, then drops lock while still driving wrong bits. It checks that the status byte stays frozen. A second run drops lock before the threshold to show that the status clears and the generator reloads.

// File: rtl/prbs_chk_pkg.sv
`timescale 1ns/1ps
package prbs_chk_pkg;
  localparam int unsigned PRBS_ORDER = 7;

  // next bit of x^7 + x^6 + 1: b[n] = b[n-7] ^ b[n-6]; hist[0] is the newest bit
  function automatic logic prbs7_predict(input logic [PRBS_ORDER-1:0] hist);
    return hist[6] ^ hist[5];
  endfunction
endpackage

// File: rtl/chk_mode_filter.sv
`timescale 1ns/1ps
module chk_mode_filter #(
  parameter int unsigned ENTRY_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic test_en,
  output logic mode_on
);
  localparam int unsigned CW = $clog2(ENTRY_CYC + 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst || !test_en) begin
      run     <= '0;
      mode_on <= 1'b0;
    end else begin
      if (run != CW'(ENTRY_CYC)) run <= run + 1'b1;
      if (run == CW'(ENTRY_CYC - 1)) mode_on <= 1'b1;
    end
  end
endmodule

// File: rtl/chk_prbs7_ref.sv
`timescale 1ns/1ps
module chk_prbs7_ref
  import prbs_chk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic bit_ok,
  input  logic bit_in,
  output logic mismatch
);
  localparam int unsigned SCW = $clog2(PRBS_ORDER + 1);

  logic [PRBS_ORDER-1:0] hist;
  logic [SCW-1:0]        seed_cnt;
  logic                  seeded;
  logic                  exp_bit;

  assign seeded   = (seed_cnt == SCW'(PRBS_ORDER));
  assign exp_bit  = prbs7_predict(hist);
  assign mismatch = bit_ok && seeded && (bit_in != exp_bit);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      hist     <= '0;
      seed_cnt <= '0;
    end else if (bit_ok) begin
      if (!seeded) begin
        hist     <= {hist[PRBS_ORDER-2:0], bit_in};
        seed_cnt <= seed_cnt + 1'b1;
      end else begin
        // free-running reference: a corrupted bit does not disturb later predictions
        hist <= {hist[PRBS_ORDER-2:0], exp_bit};
      end
    end
  end
endmodule

// File: rtl/chk_lane_status.sv
`timescale 1ns/1ps
module chk_lane_status #(
  parameter int unsigned PASS_COUNT = 44_000_000,
  parameter int unsigned ERR_W      = 7,
  parameter int unsigned SYM_W      = $clog2(PASS_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             sym_tick,
  input  logic             err_tick,
  output logic [SYM_W-1:0] sym_cnt,
  output logic [ERR_W-1:0] err_cnt,
  output logic             pass
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sym_cnt <= '0;
      err_cnt <= '0;
      pass    <= 1'b0;
    end else begin
      if (sym_tick && sym_cnt != SYM_W'(PASS_COUNT)) begin
        sym_cnt <= sym_cnt + 1'b1;
        if (sym_cnt == SYM_W'(PASS_COUNT - 1)) pass <= 1'b1;
      end
      if (err_tick && err_cnt != '1) err_cnt <= err_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/prbs7_lane_checker.sv
`timescale 1ns/1ps
module prbs7_lane_checker #(
  parameter int unsigned PASS_COUNT = 44_000_000,
  parameter int unsigned ERR_W      = 7,
  parameter int unsigned ENTRY_CYC  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             test_en,
  input  logic             lock,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic [ERR_W:0]   data_in,
  output logic [ERR_W:0]   data_out
);
  localparam int unsigned SYM_W = $clog2(PASS_COUNT + 1);

  logic             mode_on;
  logic             bit_ok;
  logic             mismatch;
  logic             clr;
  logic [SYM_W-1:0] sym_cnt;
  logic [ERR_W-1:0] err_cnt;
  logic             pass;

  chk_mode_filter #(.ENTRY_CYC(ENTRY_CYC)) u_mode (
    .clk     (clk),
    .rst     (rst),
    .test_en (test_en),
    .mode_on (mode_on)
  );

  assign bit_ok = bit_vld && mode_on && lock;
  assign clr    = !mode_on || (!lock && !pass);

  chk_prbs7_ref u_ref (
    .clk      (clk),
    .rst      (rst),
    .restart  (!mode_on || !lock),
    .bit_ok   (bit_ok),
    .bit_in   (bit_in),
    .mismatch (mismatch)
  );

  chk_lane_status #(.PASS_COUNT(PASS_COUNT), .ERR_W(ERR_W), .SYM_W(SYM_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .sym_tick (bit_ok),
    .err_tick (mismatch),
    .sym_cnt  (sym_cnt),
    .err_cnt  (err_cnt),
    .pass     (pass)
  );

  always_ff @(posedge clk) begin
    if (rst)          data_out <= '0;
    else if (mode_on) data_out <= {err_cnt, pass};
    else              data_out <= data_in;
  end
endmodule

// File: rtl/prbs7_lane_sva.sv
`timescale 1ns/1ps
module prbs7_lane_sva #(
  parameter int unsigned PASS_COUNT = 44_000_000,
  parameter int unsigned ERR_W      = 7
) (
  input logic                                clk,
  input logic                                rst,
  input logic                                test_en,
  input logic                                lock,
  input logic                                mode_on,
  input logic                                pass,
  input logic [ERR_W-1:0]                    err_cnt,
  input logic [$clog2(PASS_COUNT + 1)-1:0]   sym_cnt,
  input logic [ERR_W:0]                      data_in,
  input logic [ERR_W:0]                      data_out
);
  localparam int unsigned SYM_W = $clog2(PASS_COUNT + 1);

  a_r1_passthrough: assert property (@(posedge clk) disable iff (rst)
    !mode_on |=> data_out == $past(data_in));

  a_r2_mode_needs_request: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_on) |-> $past(test_en));

  a_r2_mode_drops: assert property (@(posedge clk) disable iff (rst)
    !test_en |=> !mode_on);

  a_r4_err_steps_by_one: assert property (@(posedge clk) disable iff (rst)
    err_cnt != $past(err_cnt) |-> (err_cnt == $past(err_cnt) + 1'b1) || (err_cnt == '0));

  a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (err_cnt == '1) && mode_on && test_en && (lock || pass) |=> err_cnt == '1);

  a_r6_no_early_pass: assert property (@(posedge clk) disable iff (rst)
    $rose(pass) |-> $past(sym_cnt) == SYM_W'(PASS_COUNT - 1));

  a_r7_pass_sticky: assert property (@(posedge clk) disable iff (rst)
    pass && mode_on && test_en |=> pass);

  a_r8_unlocked_clear: assert property (@(posedge clk) disable iff (rst)
    mode_on && !lock && !pass |=> (err_cnt == '0) && (sym_cnt == '0));

  a_r9_status_layout: assert property (@(posedge clk) disable iff (rst)
    mode_on |=> data_out == {$past(err_cnt), $past(pass)});
endmodule

bind prbs7_lane_checker prbs7_lane_sva #(.PASS_COUNT(PASS_COUNT), .ERR_W(ERR_W)) u_sva (
  .clk      (clk),
  .rst      (rst),
  .test_en  (test_en),
  .lock     (lock),
  .mode_on  (mode_on),
  .pass     (pass),
  .err_cnt  (err_cnt),
  .sym_cnt  (sym_cnt),
  .data_in  (data_in),
  .data_out (data_out)
);

// File: tb/test_prbs7_lane_checker.sv
`timescale 1ns/1ps
module test_prbs7_lane_checker;
  localparam int unsigned PASS_N = 40;
  localparam int unsigned ENTRY  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       test_en = 1'b0;
  logic       lock = 1'b1;
  logic       bit_vld = 1'b0;
  logic       bit_in = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic [7:0] data_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [6:0] g;

  always #5 clk = ~clk;

  prbs7_lane_checker #(.PASS_COUNT(PASS_N), .ERR_W(7), .ENTRY_CYC(ENTRY)) i_prbs7_lane_checker (
    .clk(clk), .rst(rst), .test_en(test_en), .lock(lock),
    .bit_vld(bit_vld), .bit_in(bit_in), .data_in(data_in), .data_out(data_out)
  );

  // {bits sent, flip period (0 = none), expected errors, expected pass}
  localparam logic [31:0] VEC [6] = '{
    {8'd20, 8'd0,  8'd0,  8'd0},
    {8'd40, 8'd0,  8'd0,  8'd1},
    {8'd39, 8'd0,  8'd0,  8'd0},
    {8'd30, 8'd10, 8'd2,  8'd0},
    {8'd60, 8'd7,  8'd8,  8'd1},
    {8'd20, 8'd1,  8'd13, 8'd0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: data_out=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_vld = 1'b0;
    end
  endtask

  task automatic send(input int n, input int every);
    for (int i = 0; i < n; i++) begin
      logic b;
      logic flip;
      @(negedge clk);
      b    = g[6] ^ g[5];
      g    = {g[5:0], b};
      flip = (every != 0) && (i >= 7) && (i % every == 0);
      bit_in  = b ^ flip;
      bit_vld = 1'b1;
    end
  endtask

  // emit the 7 stored history bits oldest first, then generation continues from them
  task automatic send_seed(input logic [6:0] s);
    for (int i = 6; i >= 0; i--) begin
      @(negedge clk);
      bit_in  = s[i];
      bit_vld = 1'b1;
    end
    g = s;
  endtask

  task automatic enter();
    @(negedge clk);
    test_en = 1'b0;
    bit_vld = 1'b0;
    @(negedge clk);
    test_en = 1'b1;
    idle(ENTRY + 2);
    g = 7'h7F;
  endtask

  initial begin
    idle(2);
    check("R1 reset", data_out, 8'h00);
    rst = 1'b0;
    data_in = 8'hA5;
    idle(2);
    check("R1 passthrough", data_out, 8'hA5);

    // R2 entry qualifier: ENTRY edges to engage, one more for data_out
    data_in = 8'h5A;
    @(negedge clk);
    test_en = 1'b1;
    idle(ENTRY);
    check("R2 not yet engaged", data_out, 8'h5A);
    idle(1);
    check("R2 engaged", data_out, 8'h00);

    for (int v = 0; v < 6; v++) begin
      enter();
      send(int'(VEC[v][31:24]), int'(VEC[v][23:16]));
      idle(3);
      check($sformatf("R4 R6 R9 vector %0d", v), data_out, {VEC[v][14:8], VEC[v][0]});
    end

    // R3 arbitrary seed is never counted, comparison then follows it
    enter();
    send_seed(7'b1011001);
    idle(3);
    check("R3 seed bits not compared", data_out, 8'h00);
    send(17, 0);
    idle(3);
    check("R3 sequence from seed", data_out, 8'h00);

    // R5 saturation, with R7 errors after pass
    enter();
    send(200, 1);
    idle(3);
    check("R5 saturate at 127", data_out, 8'hFF);

    // R7 pass sticky against later errors and lock loss
    enter();
    send(40, 0);
    send(20, 1);
    idle(3);
    check("R7 pass holds through errors", data_out, 8'd27);
    lock = 1'b0;
    idle(3);
    check("R8 lock loss after pass keeps status", data_out, 8'd27);
    send(20, 1);
    idle(3);
    check("R8 bits ignored while unlocked", data_out, 8'd27);
    lock = 1'b1;
    idle(2);

    // R8 lock loss before pass clears and reseeds
    enter();
    send(20, 5);
    idle(3);
    check("R8 errors before lock loss", data_out, 8'd4);
    lock = 1'b0;
    idle(3);
    check("R8 clear on lock loss", data_out, 8'h00);
    lock = 1'b1;
    g = 7'h7F;
    send(10, 0);
    idle(3);
    check("R8 reseed after lock", data_out, 8'h00);
    send(30, 0);
    idle(3);
    check("R8 symbol count restarted", data_out, 8'h01);

    // R11 strobe low: wrong bits ignored
    enter();
    send(10, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      bit_vld = 1'b0;
      bit_in  = ~bit_in;
    end
    send(10, 0);
    idle(3);
    check("R11 unstrobed bits ignored", data_out, 8'h00);

    // R10 exit restores passthrough, re-entry starts cleared
    send(30, 1);
    idle(3);
    data_in = 8'h3C;
    @(negedge clk);
    test_en = 1'b0;
    idle(2);
    check("R10 exit to passthrough", data_out, 8'h3C);
    enter();
    check("R10 re-entry cleared", data_out, 8'h00);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule